// File: doc/BRIEF.md
# Two-Party Mailbox Register Channel

This block is one message channel between two processor cores, called side A and side B. Each core has its own register window. A window holds seven payload words, one acknowledge word, a doorbell, a status register, a write-one-to-clear register and an interrupt mask. Both cores reach both windows through one 32-bit register port each. Address bit 12 clear selects the core's own window. Address bit 12 set selects the other core's window. A sender writes its message into the receiver's window and then rings the receiver's doorbell.

Ringing a doorbell raises one status bit in that window. The bit index is the ringing core's number with the window owner's own number removed from the count. For a system of `NUM_CORES` cores this gives `NUM_CORES-1` status bits. The doorbell has a one-cycle state machine with two states:

- `DB_IDLE` is the resting state. Transition *ring*: a doorbell write with bit 6 (data ready) or bit 7 (acknowledge) set moves it to `DB_RING`.
- `DB_RING` lasts one cycle and sets the status bit. Transition *release*: it returns to `DB_IDLE` unless a new ring arrives, which keeps it in `DB_RING`.

Each window drives a registered, level-sensitive interrupt to its owner: the OR over status AND mask.

Top module: `mbx_channel`

## Requirements
- R1: After reset every register is zero, both interrupts are low and every read returns 0.
- R2: Payload words at offsets 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28, 0x2C and the acknowledge word at 0x30 store 32-bit writes. Either port can read them back, using offset bit 12 = 0 for its own window and 1 for the peer's window.
- R3: A write to the doorbell at 0x10 with bit 6 or bit 7 set raises the status bit (offset 0x00) of the peer one clock after the write. In A's window the peer is core B; in B's window it is core A. The bit index is the peer's core number, minus one if it is above the owner's number. With the defaults (A = core 0, B = core 2) this is bit 1 in A's window and bit 0 in B's window. Doorbell bits other than 6 and 7 have no effect.
- R4: The doorbell self-clears: it holds the written bits 7:6 for one cycle only, so a later read of 0x10 returns 0.
- R5: Writing a 1 to a bit of the clear register (0x04) clears that status bit. Written 0 bits leave status unchanged. Reading 0x04 returns 0.
- R6: When a doorbell set and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Each interrupt output is high one cycle after any status bit is set whose mask bit (0x0C) is 1. It is low when the mask is zero.
- R8: Unaligned offsets and offsets not listed above (for example 0x08 and 0x34) read 0, and writes to them change nothing.
- R9: If both ports write the same window in one cycle, the owner's write takes effect and the peer's is dropped.
- R10: Status is read-only: writes to 0x00 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | ADDR_W | Side A byte address; top bit selects the peer window |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, valid the cycle after `a_rd` |
| a_irq | output | 1 | Interrupt from A's window |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | ADDR_W | Side B byte address; top bit selects the peer window |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, valid the cycle after `b_rd` |
| b_irq | output | 1 | Interrupt from B's window |

## Verification
The assertions check the following on every cycle:

- the doorbell state machine always leaves `DB_RING` after one cycle when no new ring arrives;
- a ring always leaves its status bit set, even when a clear hits it in the same cycle;
- cleared bits drop;
- status holds when no set or clear is active;
- a zero mask keeps the interrupt low.

The bench scenarios show what a single cycle cannot:

- payload contents as seen through both address paths;
- the peer-number bit mapping in each direction;
- owner priority when both ports write the same window;
- the silence of unmapped and unaligned offsets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // word indices (byte offset >> 2) inside one window
    localparam int WIDX_W   = 4;
    localparam int W_STAT   = 0;
    localparam int W_CLR    = 1;
    localparam int W_MASK   = 3;
    localparam int W_DOOR   = 4;
    localparam int W_PAY0   = 5;
    localparam int W_ACK    = 12;

    // doorbell bit positions
    localparam int DB_DATA_BIT = 6;
    localparam int DB_ACK_BIT  = 7;

    typedef enum logic {
        DB_IDLE = 1'b0,
        DB_RING = 1'b1
    } db_state_e;

    // status bit index of a sender as seen by an owner: skip the owner
    function automatic int peer_bit(input int sender, input int owner);
        return (sender < owner) ? sender : sender - 1;
    endfunction

endpackage

// File: rtl/mbx_window.sv
module mbx_window
    import mbx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NPAY     = 7,
    parameter int NST      = 3,
    parameter int OFF_W    = 12,
    parameter int RING_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [DW-1:0]        wr_data,
    output logic [NST-1:0]       stat_o,
    output logic [NST-1:0]       mask_o,
    output logic [1:0]           door_o,
    output logic [NPAY*DW-1:0]   pay_o,
    output logic [DW-1:0]        ack_o,
    output logic                 irq_o
);

    logic [DW-1:0]     pay_q [NPAY];
    logic [DW-1:0]     ack_q;
    logic [NST-1:0]    stat_q, mask_q, set_vec, clr_vec;
    logic [1:0]        door_q;
    logic              irq_q;
    db_state_e         state_q, state_d;

    logic              mapped;
    logic [WIDX_W-1:0] widx;
    logic              wr_clr, wr_mask, wr_door, wr_ack, door_hit;

    assign mapped   = (wr_off[1:0] == 2'b00) && (wr_off[OFF_W-1:6] == '0);
    assign widx     = wr_off[5:2];
    assign wr_clr   = wr_en && mapped && (widx == WIDX_W'(W_CLR));
    assign wr_mask  = wr_en && mapped && (widx == WIDX_W'(W_MASK));
    assign wr_door  = wr_en && mapped && (widx == WIDX_W'(W_DOOR));
    assign wr_ack   = wr_en && mapped && (widx == WIDX_W'(W_ACK));
    assign door_hit = wr_door && (wr_data[DB_DATA_BIT] || wr_data[DB_ACK_BIT]);

    // doorbell state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_IDLE: state_d = door_hit ? DB_RING : DB_IDLE;
            DB_RING: state_d = door_hit ? DB_RING : DB_IDLE;
            default: state_d = DB_IDLE;
        endcase
    end

    // outputs of the doorbell machine: set vector for status
    always_comb begin
        set_vec = '0;
        unique case (state_q)
            DB_IDLE: set_vec = '0;
            DB_RING: set_vec[RING_BIT] = 1'b1;
            default: set_vec = '0;
        endcase
        clr_vec = wr_clr ? wr_data[NST-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
            door_q <= '0;
            ack_q  <= '0;
            irq_q  <= 1'b0;
            for (int i = 0; i < NPAY; i++) pay_q[i] <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
            door_q <= door_hit ? wr_data[DB_ACK_BIT:DB_DATA_BIT] : 2'b00;
            irq_q  <= |(stat_q & mask_q);
            if (wr_mask) mask_q <= wr_data[NST-1:0];
            if (wr_ack)  ack_q  <= wr_data;
            for (int i = 0; i < NPAY; i++) begin
                if (wr_en && mapped && (widx == WIDX_W'(W_PAY0 + i)))
                    pay_q[i] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < NPAY; g++) begin : g_pay
        assign pay_o[g*DW +: DW] = pay_q[g];
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign door_o = door_q;
    assign ack_o  = ack_q;
    assign irq_o  = irq_q;

    // R4: doorbell machine releases after one cycle without a new ring
    p_door_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_RING && !door_hit) |=> (state_q == DB_IDLE && door_q == 2'b00));

    // R6: a ring leaves its status bit set even against a same-cycle clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DB_RING) |=> stat_q[RING_BIT]);

    // R5: cleared bits that are not being set drop
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((stat_q & $past(wr_data[NST-1:0] & ~set_vec)) == '0));

    // R7: zero mask keeps the interrupt low
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_q);

    // R10: status changes only through ring or clear
    p_stat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_clr && state_q == DB_IDLE) |=> $stable(stat_q));

endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NPAY  = 7,
    parameter int NST   = 3,
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0]   off,
    input  logic [NST-1:0]     stat,
    input  logic [NST-1:0]     mask,
    input  logic [1:0]         door,
    input  logic [NPAY*DW-1:0] pay,
    input  logic [DW-1:0]      ack,
    output logic [DW-1:0]      word
);

    logic              mapped;
    logic [WIDX_W-1:0] widx;

    assign mapped = (off[1:0] == 2'b00) && (off[OFF_W-1:6] == '0);
    assign widx   = off[5:2];

    always_comb begin
        word = '0;
        if (mapped) begin
            if (widx == WIDX_W'(W_STAT)) word[NST-1:0] = stat;
            if (widx == WIDX_W'(W_MASK)) word[NST-1:0] = mask;
            if (widx == WIDX_W'(W_DOOR)) word[DB_ACK_BIT:DB_DATA_BIT] = door;
            if (widx == WIDX_W'(W_ACK))  word = ack;
            for (int i = 0; i < NPAY; i++) begin
                if (widx == WIDX_W'(W_PAY0 + i)) word = pay[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_A    = 0,
    parameter int CORE_B    = 2,
    parameter int DW        = 32,
    parameter int NPAY      = 7,
    parameter int ADDR_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    output logic              a_irq,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata,
    output logic              b_irq
);

    localparam int OFF_W    = ADDR_W - 1;
    localparam int NST      = NUM_CORES - 1;
    localparam int BIT_IN_A = peer_bit(CORE_B, CORE_A);
    localparam int BIT_IN_B = peer_bit(CORE_A, CORE_B);

    logic              p_wr   [2];
    logic              p_rd   [2];
    logic [ADDR_W-1:0] p_addr [2];
    logic [DW-1:0]     p_wdat [2];
    logic [DW-1:0]     p_rdat [2];
    logic              w_irq  [2];

    logic [NST-1:0]     win_stat [2];
    logic [NST-1:0]     win_mask [2];
    logic [1:0]         win_door [2];
    logic [NPAY*DW-1:0] win_pay  [2];
    logic [DW-1:0]      win_ack  [2];

    assign p_wr[0] = a_wr;     assign p_wr[1] = b_wr;
    assign p_rd[0] = a_rd;     assign p_rd[1] = b_rd;
    assign p_addr[0] = a_addr; assign p_addr[1] = b_addr;
    assign p_wdat[0] = a_wdata; assign p_wdat[1] = b_wdata;

    for (genvar w = 0; w < 2; w++) begin : g_win
        localparam int RB = (w == 0) ? BIT_IN_A : BIT_IN_B;
        logic             own_hit, peer_hit;
        logic [OFF_W-1:0] sel_off;
        logic [DW-1:0]    sel_dat;

        assign own_hit  = p_wr[w]   && !p_addr[w][OFF_W];
        assign peer_hit = p_wr[1-w] &&  p_addr[1-w][OFF_W];
        // owner has priority over the peer on a same-cycle write
        assign sel_off  = own_hit ? p_addr[w][OFF_W-1:0] : p_addr[1-w][OFF_W-1:0];
        assign sel_dat  = own_hit ? p_wdat[w] : p_wdat[1-w];

        mbx_window #(
            .DW(DW), .NPAY(NPAY), .NST(NST), .OFF_W(OFF_W), .RING_BIT(RB)
        ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (own_hit || peer_hit),
            .wr_off  (sel_off),
            .wr_data (sel_dat),
            .stat_o  (win_stat[w]),
            .mask_o  (win_mask[w]),
            .door_o  (win_door[w]),
            .pay_o   (win_pay[w]),
            .ack_o   (win_ack[w]),
            .irq_o   (w_irq[w])
        );
    end

    for (genvar p = 0; p < 2; p++) begin : g_port
        logic          tgt;
        logic [DW-1:0] word, rdat_q;

        assign tgt = p_addr[p][OFF_W] ? 1'(1 - p) : 1'(p);

        mbx_rd_mux #(
            .DW(DW), .NPAY(NPAY), .NST(NST), .OFF_W(OFF_W)
        ) u_rd (
            .off  (p_addr[p][OFF_W-1:0]),
            .stat (win_stat[tgt]),
            .mask (win_mask[tgt]),
            .door (win_door[tgt]),
            .pay  (win_pay[tgt]),
            .ack  (win_ack[tgt]),
            .word (word)
        );

        always_ff @(posedge clk) begin
            if (!rst_n)       rdat_q <= '0;
            else if (p_rd[p]) rdat_q <= word;
        end
        assign p_rdat[p] = rdat_q;
    end

    assign a_rdata = p_rdat[0];
    assign b_rdata = p_rdat[1];
    assign a_irq   = w_irq[0];
    assign b_irq   = w_irq[1];

endmodule

// File: tb/mbx_channel_tb.sv
module mbx_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [12:0] a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    mbx_channel u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int p, input logic [12:0] ad, input logic [31:0] d);
        @(negedge clk);
        if (p == 0) begin a_wr = 1; a_addr = ad; a_wdata = d; end
        else        begin b_wr = 1; b_addr = ad; b_wdata = d; end
        @(negedge clk);
        a_wr = 0; b_wr = 0;
    endtask

    task automatic rd_chk(input int p, input logic [12:0] ad, input logic [31:0] exp, input string req);
        @(negedge clk);
        if (p == 0) begin a_rd = 1; a_addr = ad; end
        else        begin b_rd = 1; b_addr = ad; end
        @(negedge clk);
        a_rd = 0; b_rd = 0;
        check(req, (p == 0) ? a_rdata : b_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 a_irq", {31'b0, a_irq}, 0);
        check("R1 b_irq", {31'b0, b_irq}, 0);
        rd_chk(0, 13'h000, 0, "R1 status");
        rd_chk(0, 13'h00C, 0, "R1 mask");
        rd_chk(1, 13'h014, 0, "R1 payload");
        rd_chk(1, 13'h030, 0, "R1 ack");
    endtask

    task automatic t_payload;
        for (int i = 0; i < 7; i++) wr(0, 13'h1014 + 13'(4*i), 32'hC0DE_0000 + 32'(i*17));
        for (int i = 0; i < 7; i++) rd_chk(1, 13'h014 + 13'(4*i), 32'hC0DE_0000 + 32'(i*17), "R2 own read");
        rd_chk(0, 13'h1020, 32'hC0DE_0000 + 32'(3*17), "R2 peer read");
        wr(1, 13'h1030, 32'h1234_5678);
        rd_chk(0, 13'h030, 32'h1234_5678, "R2 ack word");
    endtask

    task automatic t_doorbell_b;
        wr(0, 13'h1010, 32'h40);
        idle(2);
        check("R7 mask zero irq low", {31'b0, b_irq}, 0);
        rd_chk(1, 13'h000, 32'h1, "R3 B status bit0");
        rd_chk(1, 13'h010, 32'h0, "R4 doorbell cleared");
        rd_chk(0, 13'h000, 32'h0, "R3 A status untouched");
        wr(1, 13'h00C, 32'h7);
        idle(1);
        check("R7 irq high", {31'b0, b_irq}, 1);
        wr(1, 13'h004, 32'h1);
        rd_chk(1, 13'h000, 32'h0, "R5 cleared");
        check("R7 irq drops", {31'b0, b_irq}, 0);
        rd_chk(1, 13'h004, 32'h0, "R5 clear reads zero");
    endtask

    task automatic t_doorbell_a;
        wr(1, 13'h1010, 32'h80);
        idle(2);
        rd_chk(0, 13'h000, 32'h2, "R3 A status bit1");
        wr(0, 13'h00C, 32'h1);
        idle(2);
        check("R7 unmasked bit no irq", {31'b0, a_irq}, 0);
        wr(0, 13'h004, 32'h7);
        rd_chk(0, 13'h000, 32'h0, "R5 clear all");
        wr(1, 13'h1010, 32'hFFFF_FF3F);
        idle(2);
        rd_chk(0, 13'h000, 32'h0, "R3 other doorbell bits ignored");
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        a_wr = 1; a_addr = 13'h1010; a_wdata = 32'h40;
        @(negedge clk);
        a_wr = 0; b_wr = 1; b_addr = 13'h004; b_wdata = 32'h1;
        @(negedge clk);
        b_wr = 0;
        rd_chk(1, 13'h000, 32'h1, "R6 set wins over clear");
        wr(1, 13'h004, 32'h6);
        rd_chk(1, 13'h000, 32'h1, "R5 zero bits keep status");
        wr(1, 13'h000, 32'h0);
        rd_chk(1, 13'h000, 32'h1, "R10 status write ignored");
        wr(0, 13'h000, 32'h7);
        rd_chk(0, 13'h000, 32'h0, "R10 status write no set");
    endtask

    task automatic t_unmapped;
        wr(0, 13'h008, 32'hFFFF_FFFF);
        rd_chk(0, 13'h008, 32'h0, "R8 offset 0x08");
        wr(0, 13'h034, 32'hFFFF_FFFF);
        rd_chk(0, 13'h034, 32'h0, "R8 offset 0x34");
        wr(0, 13'h1016, 32'hDEAD_0000);
        rd_chk(1, 13'h014, 32'hC0DE_0000, "R8 unaligned write dropped");
        rd_chk(1, 13'h016, 32'h0, "R8 unaligned read");
        rd_chk(1, 13'h054, 32'h0, "R8 offset 0x54");
    endtask

    task automatic t_owner_wins;
        @(negedge clk);
        a_wr = 1; a_addr = 13'h018; a_wdata = 32'hAAAA_AAAA;
        b_wr = 1; b_addr = 13'h1018; b_wdata = 32'h5555_5555;
        @(negedge clk);
        a_wr = 0; b_wr = 0;
        rd_chk(0, 13'h018, 32'hAAAA_AAAA, "R9 owner wins");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_payload();
        t_doorbell_b();
        t_doorbell_a();
        t_set_wins();
        t_unmapped();
        t_owner_wins();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule